// File: doc/BRIEF.md
# Double-Precision Row Slicer for Integer Matrix Emulation

This block prepares rows of double-precision values for a matrix multiply that is carried out on 8-bit integer hardware. Doubles arrive one per beat on a ready/valid stream, and a marker flags the last element of each row. The block holds the whole row in a buffer and tracks the largest exponent while the row comes in. Once the row is complete, it plays the elements back in arrival order. Each element's significand is shifted right so that it lines up with that shared row exponent. The aligned magnitude is then cut into a fixed number of unsigned bytes, and the sign is carried on its own bit.

Any infinity or NaN in a row raises a row-wide exception flag, so that the consumer can send that row down a native path instead. When alignment discards nonzero low-order bits, a per-element loss flag reports it. A row with no nonzero finite value reports exponent zero. The integer products, the reconstruction of the result and the choice of slice count all belong to the surrounding datapath.

Top module: `fp64_slice_splitter`

## Requirements
- R1: `in_ready` is high while a row is being collected and low while a row is being emitted. A row ends on the beat that carries `in_last`, or on the ROW_MAX-th accepted beat, whichever comes first.
- R2: Elements leave in arrival order, one per `out_valid`/`out_ready` handshake, and `out_last` is high only on the final element. While `out_ready` is low, every output holds its value.
- R3: A value whose 11-bit exponent field (bits 62:52) is nonzero is decoded with an implicit leading one above its 52 fraction bits (bits 51:0). A value whose exponent field is zero is decoded with effective exponent 1 and no implicit bit.
- R4: `out_exp` equals the largest effective biased exponent among the row's finite nonzero elements, and it is the same for every element of the row.
- R5: The aligned magnitude is the 53-bit significand, zero-extended at the top to NSLICE*SLICE_W bits and shifted right by (`out_exp` minus the element's effective exponent). With the defaults, the 3 top bits are zero headroom.
- R6: Slice 0 is the most significant byte of the aligned magnitude and sits in `out_slices[NSLICE*SLICE_W-1 -: SLICE_W]`. The following slices sit at successively lower byte positions.
- R7: `out_sign` is bit 63 of the input. The slices always carry the unsigned magnitude, including for negative values.
- R8: `out_sticky` is high exactly when nonzero significand bits fall below the least significant slice during alignment. A shift of NSLICE*SLICE_W bits or more drops the whole significand.
- R9: An element whose exponent field is all ones (infinity or NaN) raises `out_exc` on every element of its row. Such an element produces zero slices and a clear sticky flag, and it does not take part in the row maximum.
- R10: A row in which no element is both finite and nonzero reports `out_exp` = 0 and zero slices for every element.
- R11: Rows that follow one another are independent: the exponent and exception state start afresh for each row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 64 | Double-precision value |
| in_last | input | 1 | Beat is the last element of its row |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer takes the output element |
| out_sign | output | 1 | Sign of the element |
| out_slices | output | NSLICE*SLICE_W | Unsigned slices, slice 0 in the top byte |
| out_sticky | output | 1 | Nonzero bits lost in alignment |
| out_exp | output | 11 | Shared biased row exponent |
| out_exc | output | 1 | Row contains an infinity or NaN |
| out_last | output | 1 | Final element of the row |

## Verification
The bench builds the block with its defaults: ROW_MAX = 16, NSLICE = 7 and SLICE_W = 8. With those values, a row with no last marker reaches the length cap after only sixteen beats. A 56-bit aligned field leaves three headroom bits above the significand, and the expected top bytes can be written out by hand. Exponent spans of one, of more than 56 and of the full finite range exercise the partial shift, the total loss and the sticky flag. Subnormal, zero, infinity and NaN inputs exercise the decode and exception paths.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DBL_W = 64;
  localparam int EXP_W = 11;
  localparam int FRC_W = 52;
  localparam int SIG_W = FRC_W + 1;

  // One decoded element as held in the row buffer
  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;      // effective biased exponent
    logic [SIG_W-1:0] sig;      // significand incl. implicit bit
    logic             special;  // infinity or NaN
    logic             zero;     // +0 or -0
  } rs_elem_t;

  typedef enum logic {ST_FILL = 1'b0, ST_DRAIN = 1'b1} rs_state_e;
endpackage

// File: rtl/rs_unpack.sv
module rs_unpack
  import rs_pkg::*;
(
  input  logic [DBL_W-1:0] word,
  output rs_elem_t         elem
);
  logic [EXP_W-1:0] field;

  always_comb begin
    field        = word[DBL_W-2:FRC_W];
    elem.sign    = word[DBL_W-1];
    elem.special = &field;
    elem.zero    = (word[DBL_W-2:0] == '0);
    if (field == '0) begin
      // subnormal or zero: exponent 1, no hidden bit
      elem.exp = EXP_W'(1);
      elem.sig = {1'b0, word[FRC_W-1:0]};
    end else begin
      elem.exp = field;
      elem.sig = {1'b1, word[FRC_W-1:0]};
    end
  end
endmodule

// File: rtl/rs_align.sv
module rs_align
  import rs_pkg::*;
#(
  parameter int NSLICE  = 7,
  parameter int SLICE_W = 8
) (
  input  rs_elem_t                    elem,
  input  logic [EXP_W-1:0]            row_exp,
  output logic [NSLICE*SLICE_W-1:0]   mag,
  output logic                        sticky
);
  localparam int W = NSLICE * SLICE_W;
  localparam logic [EXP_W-1:0] W_E = EXP_W'(W);

  logic [EXP_W-1:0] shift;
  logic [W-1:0]     ext;
  logic [W-1:0]     lost_mask;

  always_comb begin
    shift     = (row_exp > elem.exp) ? (row_exp - elem.exp) : '0;
    ext       = W'(elem.sig);
    lost_mask = '0;
    mag       = '0;
    sticky    = 1'b0;
    if (elem.special || elem.zero) begin
      mag    = '0;
      sticky = 1'b0;
    end else if (shift >= W_E) begin
      mag    = '0;
      sticky = |elem.sig;
    end else begin
      lost_mask = (W'(1) << shift) - W'(1);
      mag       = ext >> shift;
      sticky    = |(ext & lost_mask);
    end
  end
endmodule

// File: rtl/fp64_slice_splitter.sv
module fp64_slice_splitter
  import rs_pkg::*;
#(
  parameter int ROW_MAX = 16,
  parameter int NSLICE  = 7,
  parameter int SLICE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [63:0]               in_data,
  input  logic                      in_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_sign,
  output logic [NSLICE*SLICE_W-1:0] out_slices,
  output logic                      out_sticky,
  output logic [10:0]               out_exp,
  output logic                      out_exc,
  output logic                      out_last
);
  localparam int W     = NSLICE * SLICE_W;
  localparam int IDX_W = (ROW_MAX > 1) ? $clog2(ROW_MAX) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROW_MAX - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  rs_state_e        state_q, state_d;
  logic [IDX_W-1:0] wr_q, wr_d, rd_q, rd_d, lastidx_q, lastidx_d;
  logic [EXP_W-1:0] rexp_q, rexp_d;
  logic             exc_q, exc_d;
  rs_elem_t         buf_q [ROW_MAX];

  rs_elem_t         in_elem, out_elem;
  logic             acc, pop;
  logic [W-1:0]     mag;
  logic             sticky;

  rs_unpack u_unpack (.word(in_data), .elem(in_elem));

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_DRAIN);
  assign acc       = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_elem  = buf_q[rd_q];

  // next-state logic
  always_comb begin
    state_d   = state_q;
    wr_d      = wr_q;
    rd_d      = rd_q;
    lastidx_d = lastidx_q;
    rexp_d    = rexp_q;
    exc_d     = exc_q;
    if (acc) begin
      wr_d  = wr_q + 1'b1;
      exc_d = exc_q | in_elem.special;
      if (!in_elem.special && !in_elem.zero && (in_elem.exp > rexp_q))
        rexp_d = in_elem.exp;
      if (in_last || (wr_q == IDX_LAST)) begin
        state_d   = ST_DRAIN;
        lastidx_d = wr_q;
        rd_d      = '0;
      end
    end
    if (pop) begin
      if (rd_q == lastidx_q) begin
        state_d = ST_FILL;
        wr_d    = '0;
        rexp_d  = '0;
        exc_d   = 1'b0;
      end else begin
        rd_d = rd_q + 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_FILL;
      wr_q      <= '0;
      rd_q      <= '0;
      lastidx_q <= '0;
      rexp_q    <= '0;
      exc_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      wr_q      <= wr_d;
      rd_q      <= rd_d;
      lastidx_q <= lastidx_d;
      rexp_q    <= rexp_d;
      exc_q     <= exc_d;
    end
  end

  // row buffer, written with an explicit enable, no reset
  always_ff @(posedge clk) begin
    if (acc) buf_q[wr_q] <= in_elem;
  end

  rs_align #(.NSLICE(NSLICE), .SLICE_W(SLICE_W)) u_align (
    .elem(out_elem), .row_exp(rexp_q), .mag(mag), .sticky(sticky)
  );

  assign out_sign   = out_elem.sign;
  assign out_slices = mag;
  assign out_sticky = sticky;
  assign out_exp    = rexp_q;
  assign out_exc    = exc_q;
  assign out_last   = (rd_q == lastidx_q);

  // R1: the cap-length beat closes the row
  a_r1_row_cap: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc && (wr_q == IDX_LAST) |=> out_valid && !in_ready);

  // R2: outputs hold under backpressure
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slices)
      && $stable(out_last) && $stable(out_exp) && $stable(out_sign));

  // R4: no finite nonzero element sits above the row exponent
  a_r4_exp_bound: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && !out_elem.special && !out_elem.zero |-> out_elem.exp <= out_exp);

  // R8: loss only occurs on a nonzero alignment shift
  a_r8_sticky_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && out_sticky |-> out_elem.exp < out_exp);

  // R9: specials flag the row and emit nothing
  a_r9_special_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && out_elem.special |-> out_exc && (out_slices == '0) && !out_sticky);

  // R10: a zero row exponent means nothing to slice
  a_r10_zero_row: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid && (out_exp == '0) |-> (out_slices == '0));
endmodule

// File: tb/tb_fp64_slice_splitter.sv
module tb_fp64_slice_splitter;
  localparam int NV = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_sign;
  logic [55:0] out_slices;
  logic        out_sticky;
  logic [10:0] out_exp;
  logic        out_exc;
  logic        out_last;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp64_slice_splitter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_sign(out_sign), .out_slices(out_slices),
    .out_sticky(out_sticky), .out_exp(out_exp), .out_exc(out_exc),
    .out_last(out_last)
  );

  // {last, value}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 64'h3FF0000000000000}, {1'b0, 64'hBFE0000000000000},
    {1'b1, 64'h4008000000000000},
    {1'b0, 64'h0000000000000000}, {1'b1, 64'h8000000000000000},
    {1'b0, 64'h3FF0000000000000}, {1'b1, 64'h7FF0000000000000},
    {1'b1, 64'h7FF8000000000000},
    {1'b0, 64'h0000000000000001}, {1'b1, 64'h0010000000000000},
    {1'b0, 64'h3FF0000000000000}, {1'b1, 64'h39B0000000000000},
    {1'b0, 64'h4000000000000000}, {1'b1, 64'h3FF0000000000001},
    {1'b0, 64'h400921FB54442D18}, {1'b0, 64'hC005BF0A8B145769},
    {1'b0, 64'h3F50624DD2F1A9FC}, {1'b1, 64'h7FEFFFFFFFFFFFFF},
    {1'b1, 64'hFFF0000000000000}
  };

  logic [63:0] row [16];
  int          row_n;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_spec(input logic [63:0] w);
    return &w[62:52];
  endfunction

  function automatic logic [10:0] model_exp();
    logic [10:0] m = '0;
    for (int i = 0; i < row_n; i++) begin
      logic [10:0] e = (row[i][62:52] == 0) ? 11'd1 : row[i][62:52];
      if (!is_spec(row[i]) && row[i][62:0] != 0 && e > m) m = e;
    end
    return m;
  endfunction

  function automatic logic model_exc();
    logic x = 1'b0;
    for (int i = 0; i < row_n; i++) x |= is_spec(row[i]);
    return x;
  endfunction

  task automatic model_elem(input logic [63:0] w, input logic [10:0] e_row,
                            output logic [55:0] mag, output logic st);
    logic [55:0] s;
    logic [10:0] e;
    int d;
    e = (w[62:52] == 0) ? 11'd1 : w[62:52];
    s = (w[62:52] == 0) ? {4'b0, w[51:0]} : {3'b0, 1'b1, w[51:0]};
    d = (e_row > e) ? int'(e_row) - int'(e) : 0;
    if (is_spec(w)) begin mag = '0; st = 1'b0; end
    else if (d >= 56) begin mag = '0; st = (s != 0); end
    else begin mag = s >> d; st = ((mag << d) != s); end
  endtask

  task automatic send(input logic [63:0] w, input logic last);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1 ready while filling",
          {62'b0, in_ready, out_valid}, 64'h2);
    in_valid = 1'b1; in_data = w; in_last = last;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic take(input int i, input logic [10:0] e_row, input logic exc);
    logic [55:0] mag;
    logic st;
    model_elem(row[i], e_row, mag, st);
    check(out_valid === 1'b1 && in_ready === 1'b0, "R1/R2 valid while emitting",
          {62'b0, out_valid, in_ready}, 64'h2);
    check(out_slices === mag, "R5/R6 slices", {8'b0, out_slices}, {8'b0, mag});
    check(out_sticky === st, "R8 sticky", {63'b0, out_sticky}, {63'b0, st});
    check(out_sign === row[i][63], "R7 sign", {63'b0, out_sign}, {63'b0, row[i][63]});
    check(out_exp === e_row, "R4/R10 row exponent", {53'b0, out_exp}, {53'b0, e_row});
    check(out_exc === exc, "R9 exception", {63'b0, out_exc}, {63'b0, exc});
    check(out_last === (i == row_n - 1), "R2 last marker", {63'b0, out_last},
          {63'b0, (i == row_n - 1)});
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_row(input bit use_last);
    logic [10:0] e_row;
    logic exc;
    for (int i = 0; i < row_n; i++) send(row[i], use_last && (i == row_n - 1));
    e_row = model_exp();
    exc = model_exc();
    for (int i = 0; i < row_n; i++) take(i, e_row, exc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", {63'b0, out_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
          {62'b0, in_ready, out_valid}, 64'h2);

    // table walk: each row checked against the requirement model
    row_n = 0;
    for (int v = 0; v < NV; v++) begin
      row[row_n] = VEC[v][63:0];
      row_n++;
      if (VEC[v][64]) begin
        run_row(1'b1);
        row_n = 0;
      end
    end

    // R3/R6 hand values: 1.0 alone -> top byte 0x10, exponent 1023
    row[0] = 64'h3FF0000000000000; row_n = 1;
    send(row[0], 1'b1);
    check(out_slices === 56'h10000000000000, "R3 R6 one top byte",
          {8'b0, out_slices}, 64'h10000000000000);
    check(out_exp === 11'd1023, "R4 single exponent", {53'b0, out_exp}, 64'd1023);
    take(0, 11'd1023, 1'b0);

    // R7: -0.5 alone, unsigned magnitude with separate sign
    row[0] = 64'hBFE0000000000000; row_n = 1;
    send(row[0], 1'b1);
    check(out_slices === 56'h10000000000000 && out_sign === 1'b1, "R7 negative magnitude",
          {7'b0, out_sign, out_slices}, 64'h0110000000000000);
    take(0, 11'd1022, 1'b0);

    // R3: smallest subnormal alone -> exponent 1, slices = 1
    row[0] = 64'h0000000000000001; row_n = 1;
    send(row[0], 1'b1);
    check(out_slices === 56'h1 && out_exp === 11'd1, "R3 subnormal",
          {out_exp, 53'b0} | {8'b0, out_slices}, 64'h0020000000000001);
    take(0, 11'd1, 1'b0);

    // R8: 2.0 then 1+ulp, one shift drops the low bit -> 0x08 top byte, sticky
    row[0] = 64'h4000000000000000; row[1] = 64'h3FF0000000000001; row_n = 2;
    send(row[0], 1'b0); send(row[1], 1'b1);
    take(0, 11'd1024, 1'b0);
    check(out_slices === 56'h08000000000000 && out_sticky === 1'b1, "R8 lost ulp",
          {7'b0, out_sticky, out_slices}, 64'h0108000000000000);
    take(1, 11'd1024, 1'b0);

    // R2 backpressure: outputs and in_ready hold while out_ready is low
    row[0] = 64'h3FF0000000000000; row[1] = 64'h4000000000000000; row_n = 2;
    send(row[0], 1'b0); send(row[1], 1'b1);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1 && in_ready === 1'b0, "R2 hold under backpressure",
          {62'b0, out_valid, in_ready}, 64'h2);
    check(out_slices === 56'h08000000000000 && out_last === 1'b0, "R2 first element held",
          {7'b0, out_last, out_slices}, 64'h0008000000000000);
    take(0, 11'd1024, 1'b0);
    take(1, 11'd1024, 1'b0);

    // R1 cap: 16 beats with no last marker close the row
    row_n = 16;
    for (int i = 0; i < 16; i++) row[i] = 64'h3FF0000000000000 | (64'(i) << 44);
    run_row(1'b0);

    // R11: an exception row followed by a clean row starts afresh
    row[0] = 64'h7FF0000000000000; row_n = 1;
    run_row(1'b1);
    row[0] = 64'h3FF0000000000000; row_n = 1;
    send(row[0], 1'b1);
    check(out_exc === 1'b0 && out_exp === 11'd1023, "R11 state cleared",
          {52'b0, out_exc, out_exp}, 64'd1023);
    take(0, 11'd1023, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule